// File: doc/BRIEF.md
# Banked Read Conflict Serializer

This block takes one read request per thread from a group of threads acting together (a warp, 32 threads by default). Each request is a byte address into an interleaved on-chip memory. The memory is split into banks, and each bank returns one 32-bit word per access slot. The block sorts the requests into passes that are free of conflicts. Each pass grants at most one thread per bank. It delivers the granted threads' read data, and it reports how many passes each half of the warp needed.

The warp is handled as two halves of equal size, always the lower-numbered half first. Threads in different halves never compete for a bank. Within a half, every pass gives each bank to the lowest-numbered thread that is still waiting for that bank. Conflicts are judged only by bank index. Two threads reading the same word in the same bank still take separate passes, because no word is shared between threads.

A small storage model sits behind the banks so that read data can be checked. Word `w` holds a fixed value computed from `w`. A caller pulses `start` with a request mask and the addresses. It then collects one grant mask and one data vector per pass, and finally a done pulse with the pass counts.

Top module: `bank_conflict_serializer`

## Requirements
- R1: The word address is the byte address shifted right by 2, and the bank is the word address modulo 16 (byte-address bits [5:2]). Byte addresses inside one 32-bit word map to the same bank and conflict: four threads that read bytes 0..3 of one word need 4 passes.
- R2: Threads 0..15 are scheduled first and threads 16..31 after them. Every pass grants threads from one half only, and `pass_half` is 0 for the lower half and 1 for the upper half.
- R3: In each pass, for every bank that has a waiting thread in the current half, exactly the lowest-numbered waiting thread is granted. A granted thread leaves the waiting set.
- R4: A half needs as many passes as the largest number of its active threads that share one bank. Examples: a stride of one word gives 1 pass, a stride of two words gives 2 passes, a stride of three words gives 1 pass, and 8 threads on one bank give 8 passes.
- R5: Each pass takes two cycles. When the start edge is cycle 0, the first pass shows up on `pass_valid` after edge 2. Later passes follow every two cycles, and `pass_valid` is high for one cycle at a time.
- R6: In a pass, lane t of `grant_data` holds the content of thread t's word if t is granted, and 0 otherwise. Word w holds (w * 0x9E3779B1 mod 2^32) XOR 0x5A5A5A5A.
- R7: Threads whose bit in `req_mask` is 0 are never granted. A half with no active threads takes zero passes and costs one cycle.
- R8: `done` pulses for one cycle after edge 2*(P0+P1)+2 counted from the start edge, where P0 and P1 are the passes of the two halves. At that point `busy` is low, `passes_lo`=P0, `passes_hi`=P1 and `passes_total`=P0+P1, and these counts hold until the next start.
- R9: After reset, `busy`, `done` and `pass_valid` are 0 and all counts are 0. A `start` that arrives while `busy` is high is ignored, and so are changes to the request inputs after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accepts a new warp request when the block is idle |
| req_mask | input | 32 | Active thread mask |
| req_addr | input | 384 | Byte address per thread, 12 bits each, thread t at bits [12t+11:12t] |
| busy | output | 1 | A request is being scheduled |
| pass_valid | output | 1 | One-cycle strobe for a finished pass |
| pass_half | output | 1 | Half that the current pass belongs to |
| grant_mask | output | 32 | Threads granted in this pass |
| grant_data | output | 1024 | Read word per thread, lane t at bits [32t+31:32t] |
| done | output | 1 | One-cycle strobe when both halves are served |
| passes_lo | output | 5 | Passes used by the lower half |
| passes_hi | output | 5 | Passes used by the upper half |
| passes_total | output | 6 | Passes used by the whole warp |

## Verification
Every result has a fixed cycle when it is due. Counting the start edge as cycle 0, pass k of the lower half appears after edge 2k. Pass j of the upper half appears after edge 2*P0+1+2j. The done strobe appears after edge 2*(P0+P1)+2. The bench builds this schedule ahead of each run from the requirements alone. It then samples the outputs a short delay after every rising edge and checks each pass strobe and each done strobe against the exact edge number it expects. A pass that arrives early, arrives late, or is missing fails the check for that pass.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARB  = 2'd1,
      ST_XFER = 2'd2
   } bcs_state_e;

   // Fixed contents of the storage model, as a function of the word address.
   function automatic logic [31:0] word_content(input logic [31:0] w);
      return (w * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
   endfunction

endpackage

// File: rtl/bcs_half_arbiter.sv
module bcs_half_arbiter #(
   parameter int LANES  = 16,
   parameter int BANK_W = 4
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*BANK_W-1:0] bank,
   output logic [LANES-1:0]        win
);

   for (genvar t = 0; t < LANES; t++) begin : g_lane
      logic blocked;
      always_comb begin
         blocked = 1'b0;
         for (int u = 0; u < t; u++) begin
            if (pend[u] && (bank[u*BANK_W +: BANK_W] == bank[t*BANK_W +: BANK_W]))
               blocked = 1'b1;
         end
      end
      assign win[t] = pend[t] & ~blocked;
   end

endmodule

// File: rtl/bcs_bank_array.sv
module bcs_bank_array
   import bcs_pkg::*;
#(
   parameter int LANES   = 16,
   parameter int N_BANKS = 16,
   parameter int BANK_W  = 4,
   parameter int ROW_W   = 6,
   parameter int DATA_W  = 32
) (
   input  logic [LANES-1:0]        sel,
   input  logic [LANES*BANK_W-1:0] bank,
   input  logic [LANES*ROW_W-1:0]  row,
   output logic [LANES*DATA_W-1:0] lane_data
);

   logic [DATA_W-1:0] bank_word [N_BANKS];

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic [ROW_W-1:0] row_sel;
      always_comb begin
         row_sel = '0;
         for (int t = 0; t < LANES; t++) begin
            if (sel[t] && (bank[t*BANK_W +: BANK_W] == BANK_W'(b)))
               row_sel = row_sel | row[t*ROW_W +: ROW_W];
         end
      end
      assign bank_word[b] = DATA_W'(word_content(32'({row_sel, BANK_W'(b)})));
   end

   for (genvar t = 0; t < LANES; t++) begin : g_out
      assign lane_data[t*DATA_W +: DATA_W] =
         sel[t] ? bank_word[bank[t*BANK_W +: BANK_W]] : '0;
   end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
   import bcs_pkg::*;
#(
   parameter int N_THREADS = 32,
   parameter int N_BANKS   = 16,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   localparam int HALF   = N_THREADS / 2,
   localparam int CNT_W  = $clog2(HALF + 1),
   localparam int TOT_W  = $clog2(N_THREADS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [N_THREADS-1:0]        req_mask,
   input  logic [N_THREADS*ADDR_W-1:0] req_addr,
   output logic                        busy,
   output logic                        pass_valid,
   output logic                        pass_half,
   output logic [N_THREADS-1:0]        grant_mask,
   output logic [N_THREADS*DATA_W-1:0] grant_data,
   output logic                        done,
   output logic [CNT_W-1:0]            passes_lo,
   output logic [CNT_W-1:0]            passes_hi,
   output logic [TOT_W-1:0]            passes_total
);

   localparam int BANK_W = $clog2(N_BANKS);
   localparam int OFS_W  = $clog2(DATA_W / 8);
   localparam int WORD_W = ADDR_W - OFS_W;
   localparam int ROW_W  = WORD_W - BANK_W;

   // Elaboration-time parameter checks
   if (N_THREADS < 2 || (N_THREADS % 2) != 0) begin : g_bad_threads
      $error("N_THREADS must be even and at least 2");
   end
   if (N_BANKS < 2 || (N_BANKS & (N_BANKS - 1)) != 0) begin : g_bad_banks
      $error("N_BANKS must be a power of two, at least 2");
   end
   if ((DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (ROW_W < 1 || WORD_W > 32) begin : g_bad_addr
      $error("ADDR_W must leave at least one row bit and at most 32 word bits");
   end

   bcs_state_e                  state_q;
   logic                        half_q;
   logic [N_THREADS-1:0]        pend_q;
   logic [N_THREADS*ADDR_W-1:0] addr_q;
   logic [HALF-1:0]             grant_q;

   // Per-thread bank and row decode of the latched addresses
   logic [N_THREADS-1:0][BANK_W-1:0] bank_all;
   logic [N_THREADS-1:0][ROW_W-1:0]  row_all;
   for (genvar t = 0; t < N_THREADS; t++) begin : g_decode
      assign bank_all[t] = addr_q[t*ADDR_W + OFS_W +: BANK_W];
      assign row_all[t]  = addr_q[t*ADDR_W + OFS_W + BANK_W +: ROW_W];
   end

   // Current half selection
   logic [HALF-1:0]        cur_pend;
   logic [HALF*BANK_W-1:0] cur_bank;
   logic [HALF*ROW_W-1:0]  cur_row;
   logic [HALF-1:0]        cur_win;
   logic [HALF*DATA_W-1:0] cur_data;

   assign cur_pend = half_q ? pend_q[N_THREADS-1:HALF]   : pend_q[HALF-1:0];
   assign cur_bank = half_q ? bank_all[N_THREADS-1:HALF] : bank_all[HALF-1:0];
   assign cur_row  = half_q ? row_all[N_THREADS-1:HALF]  : row_all[HALF-1:0];

   bcs_half_arbiter #(
      .LANES  (HALF),
      .BANK_W (BANK_W)
   ) u_arb (
      .pend (cur_pend),
      .bank (cur_bank),
      .win  (cur_win)
   );

   bcs_bank_array #(
      .LANES   (HALF),
      .N_BANKS (N_BANKS),
      .BANK_W  (BANK_W),
      .ROW_W   (ROW_W),
      .DATA_W  (DATA_W)
   ) u_banks (
      .sel       (grant_q),
      .bank      (cur_bank),
      .row       (cur_row),
      .lane_data (cur_data)
   );

   logic [N_THREADS-1:0] win_placed;
   logic [N_THREADS-1:0] grant_placed;
   logic [N_THREADS*DATA_W-1:0] data_placed;

   assign win_placed   = half_q ? {cur_win, {HALF{1'b0}}} : {{HALF{1'b0}}, cur_win};
   assign grant_placed = half_q ? {grant_q, {HALF{1'b0}}} : {{HALF{1'b0}}, grant_q};
   assign data_placed  = half_q ? {cur_data, {(HALF*DATA_W){1'b0}}}
                                : {{(HALF*DATA_W){1'b0}}, cur_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         half_q       <= 1'b0;
         pend_q       <= '0;
         addr_q       <= '0;
         grant_q      <= '0;
         pass_valid   <= 1'b0;
         pass_half    <= 1'b0;
         grant_mask   <= '0;
         grant_data   <= '0;
         done         <= 1'b0;
         passes_lo    <= '0;
         passes_hi    <= '0;
         passes_total <= '0;
      end else begin
         pass_valid <= 1'b0;
         done       <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q       <= req_addr;
                  pend_q       <= req_mask;
                  half_q       <= 1'b0;
                  passes_lo    <= '0;
                  passes_hi    <= '0;
                  passes_total <= '0;
                  state_q      <= ST_ARB;
               end
            end
            ST_ARB: begin
               if (cur_pend == '0) begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                  end else begin
                     done    <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end else begin
                  grant_q      <= cur_win;
                  pend_q       <= pend_q & ~win_placed;
                  passes_total <= passes_total + TOT_W'(1);
                  if (half_q) passes_hi <= passes_hi + CNT_W'(1);
                  else        passes_lo <= passes_lo + CNT_W'(1);
                  state_q      <= ST_XFER;
               end
            end
            ST_XFER: begin
               pass_valid <= 1'b1;
               pass_half  <= half_q;
               grant_mask <= grant_placed;
               grant_data <= data_placed;
               state_q    <= ST_ARB;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int N_THREADS = 32,
   parameter int N_BANKS   = 16,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 5,
   parameter int TOT_W     = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        busy,
   input logic                        done,
   input logic                        pass_valid,
   input logic                        pass_half,
   input logic [N_THREADS-1:0]        grant_mask,
   input logic [N_THREADS*ADDR_W-1:0] lat_addr,
   input logic [CNT_W-1:0]            passes_lo,
   input logic [CNT_W-1:0]            passes_hi,
   input logic [TOT_W-1:0]            passes_total
);

   localparam int HALF   = N_THREADS / 2;
   localparam int BANK_W = $clog2(N_BANKS);
   localparam int OFS_W  = $clog2(DATA_W / 8);

   logic dup_bank;
   always_comb begin
      dup_bank = 1'b0;
      for (int i = 0; i < N_THREADS; i++) begin
         for (int j = i + 1; j < N_THREADS; j++) begin
            if (grant_mask[i] && grant_mask[j] &&
                lat_addr[i*ADDR_W + OFS_W +: BANK_W] == lat_addr[j*ADDR_W + OFS_W +: BANK_W])
               dup_bank = 1'b1;
         end
      end
   end

   p_one_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid |-> (pass_half ? (grant_mask[HALF-1:0] == '0)
                                : (grant_mask[N_THREADS-1:HALF] == '0)));

   p_bank_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid |-> !dup_bank);

   p_pass_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid |=> !pass_valid);

   p_pass_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid |-> (grant_mask != '0));

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_total_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (passes_total == TOT_W'(passes_lo) + TOT_W'(passes_hi)));

endmodule

bind bank_conflict_serializer bcs_checker #(
   .N_THREADS (N_THREADS),
   .N_BANKS   (N_BANKS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .TOT_W     (TOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .pass_valid   (pass_valid),
   .pass_half    (pass_half),
   .grant_mask   (grant_mask),
   .lat_addr     (addr_q),
   .passes_lo    (passes_lo),
   .passes_hi    (passes_hi),
   .passes_total (passes_total)
);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NT = 32;
   localparam int HF = 16;
   localparam int AW = 12;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NT-1:0]    req_mask = '0;
   logic [NT*AW-1:0] req_addr = '0;
   logic             busy, pass_valid, pass_half, done;
   logic [NT-1:0]    grant_mask;
   logic [NT*DW-1:0] grant_data;
   logic [4:0]       passes_lo, passes_hi;
   logic [5:0]       passes_total;

   int total_checks = 0;
   int bad_checks = 0;

   logic [AW-1:0] a [NT];
   logic [NT-1:0] e_grant [64];
   int e_cyc [64];
   int e_n, e_lo, e_hi, e_done;

   bank_conflict_serializer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
      .req_addr(req_addr), .busy(busy), .pass_valid(pass_valid),
      .pass_half(pass_half), .grant_mask(grant_mask), .grant_data(grant_data),
      .done(done), .passes_lo(passes_lo), .passes_hi(passes_hi),
      .passes_total(passes_total)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 100000);
      bad_checks++;
      total_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
   end

   function automatic logic [31:0] content(input int w);
      logic [31:0] p;
      p = 32'(w) * 32'h9E37_79B1;
      return p ^ 32'h5A5A_5A5A;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total_checks++;
      if (!ok) begin
         bad_checks++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected schedule from the requirements: start edge is cycle 0.
   task automatic build_expect(input logic [NT-1:0] mask);
      logic [NT-1:0] pending;
      int t;
      pending = mask;
      t = 0;
      e_n = 0; e_lo = 0; e_hi = 0;
      for (int h = 0; h < 2; h++) begin
         for (int it = 0; it < 64; it++) begin
            logic [15:0] used;
            logic [NT-1:0] win;
            used = '0;
            win = '0;
            for (int i = h*HF; i < h*HF + HF; i++) begin
               if (pending[i] && !used[a[i][5:2]]) begin
                  used[a[i][5:2]] = 1'b1;
                  win[i] = 1'b1;
               end
            end
            if (win == '0) break;
            t += 2;
            e_grant[e_n] = win;
            e_cyc[e_n] = t;
            e_n++;
            pending &= ~win;
            if (h == 0) e_lo++; else e_hi++;
         end
         t += 1;
      end
      e_done = t;
   endtask

   task automatic run_case(input string req, input logic [NT-1:0] mask, input int poke_k);
      int pi;
      bit got_done;
      build_expect(mask);
      @(negedge clk);
      for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = a[i];
      req_mask = mask;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      pi = 0;
      got_done = 1'b0;
      for (int k = 1; k < 400; k++) begin
         @(posedge clk);
         #1 start = 1'b0;
         #1;
         if (pass_valid) begin
            if (pi < e_n) begin
               int bad_lanes;
               logic [31:0] first_act, first_exp;
               check(k == e_cyc[pi], "R5", "pass cycle", 64'(k), 64'(e_cyc[pi]));
               check(grant_mask == e_grant[pi], req, "grant mask", 64'(grant_mask), 64'(e_grant[pi]));
               check(pass_half == (e_grant[pi][HF-1:0] == '0), "R2", "pass half",
                     64'(pass_half), 64'(e_grant[pi][HF-1:0] == '0));
               bad_lanes = 0;
               first_act = '0; first_exp = '0;
               for (int i = 0; i < NT; i++) begin
                  logic [31:0] ex;
                  ex = e_grant[pi][i] ? content(int'(a[i] >> 2)) : 32'h0;
                  if (grant_data[i*DW +: DW] != ex) begin
                     if (bad_lanes == 0) begin
                        first_act = grant_data[i*DW +: DW];
                        first_exp = ex;
                     end
                     bad_lanes++;
                  end
               end
               check(bad_lanes == 0, "R6", "lane data", 64'(first_act), 64'(first_exp));
            end else begin
               check(1'b0, req, "unexpected extra pass", 64'(pi + 1), 64'(e_n));
            end
            pi++;
         end
         if (done) begin
            got_done = 1'b1;
            check(k == e_done, "R8", "done cycle", 64'(k), 64'(e_done));
            check(pi == e_n, req, "pass count seen", 64'(pi), 64'(e_n));
            check(passes_lo == 5'(e_lo), "R8", "passes_lo", 64'(passes_lo), 64'(e_lo));
            check(passes_hi == 5'(e_hi), "R8", "passes_hi", 64'(passes_hi), 64'(e_hi));
            check(passes_total == 6'(e_lo + e_hi), "R8", "passes_total",
                  64'(passes_total), 64'(e_lo + e_hi));
            check(!busy, "R8", "busy at done", 64'(busy), 64'(0));
            break;
         end
         if (k == poke_k) begin
            start = 1'b1;
            req_mask = '1;
            req_addr = '0;
         end
      end
      if (!got_done) check(1'b0, "R8", "done never seen", 64'(0), 64'(1));
   endtask

   task automatic t_reset();
      #1;
      check(busy == 1'b0, "R9", "busy after reset", 64'(busy), 64'(0));
      check(done == 1'b0, "R9", "done after reset", 64'(done), 64'(0));
      check(pass_valid == 1'b0, "R9", "pass_valid after reset", 64'(pass_valid), 64'(0));
      check(passes_total == '0, "R9", "count after reset", 64'(passes_total), 64'(0));
   endtask

   task automatic t_sequential();
      for (int i = 0; i < NT; i++) a[i] = AW'(4 * i);
      run_case("R1", 32'hFFFF_FFFF, 0);
      check(passes_lo == 5'd1 && passes_hi == 5'd1, "R4", "unit stride passes",
            64'({passes_hi, passes_lo}), 64'({5'd1, 5'd1}));
   endtask

   task automatic t_byte_subword();
      for (int i = 0; i < NT; i++) a[i] = (i < HF) ? AW'(i) : AW'(12'h300 + i);
      run_case("R1", 32'h0000_FFFF, 0);
      check(passes_lo == 5'd4, "R1", "subword 4-way", 64'(passes_lo), 64'(4));
      check(passes_hi == 5'd0, "R7", "empty upper half", 64'(passes_hi), 64'(0));
   endtask

   task automatic t_stride2();
      for (int i = 0; i < NT; i++) a[i] = AW'(8 * i);
      run_case("R4", 32'hFFFF_FFFF, 0);
      check(passes_lo == 5'd2 && passes_hi == 5'd2, "R4", "stride two passes",
            64'({passes_hi, passes_lo}), 64'({5'd2, 5'd2}));
   endtask

   task automatic t_stride3();
      for (int i = 0; i < NT; i++) a[i] = AW'(12 * i);
      run_case("R4", 32'hFFFF_FFFF, 0);
      check(passes_total == 6'd2, "R4", "stride three passes", 64'(passes_total), 64'(2));
   endtask

   task automatic t_hot_bank();
      for (int i = 0; i < NT; i++) a[i] = '0;
      for (int i = 0; i < 8; i++) a[i] = 12'h040;
      a[20] = 12'd84; a[21] = 12'd148; a[22] = 12'd212; a[23] = 12'd276;
      run_case("R3", 32'h00F0_00FF, 0);
      check(passes_lo == 5'd8 && passes_hi == 5'd4, "R4", "hot bank passes",
            64'({passes_hi, passes_lo}), 64'({5'd4, 5'd8}));
   endtask

   task automatic t_empty();
      for (int i = 0; i < NT; i++) a[i] = AW'(i);
      run_case("R7", 32'h0000_0000, 0);
   endtask

   task automatic t_busy_start();
      for (int i = 0; i < NT; i++) a[i] = AW'(8 * i + 64);
      run_case("R9", 32'h0F0F_F0F0, 2);
   endtask

   task automatic t_mixed();
      for (int i = 0; i < NT; i++) a[i] = AW'((i * i * 20 + i * 12) % 4096);
      run_case("R3", 32'hA5C3_3C5A, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_sequential();
      t_byte_subword();
      t_stride2();
      t_stride3();
      t_hot_bank();
      t_empty();
      t_busy_start();
      t_mixed();
      repeat (4) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
   end

endmodule